// File: doc/BRIEF.md
# Staged Thermal Escalation Controller

This block turns a stream of periodic temperature samples into a graded cooling and power-shedding policy for a switch chassis. Each sample carries a hotspot reading, an air-intake reading and an air-exhaust reading, together with a fan tachometer fault flag. The controller keeps a short history of hotspot values, from which it derives a trend (slope) and a windowed mean. It moves between four levels: normal, warning, derate and shutdown. Escalation is driven by slope, by absolute thresholds and by fan faults. Recovery needs hysteresis below the entry threshold, a minimum dwell in the current level and, for shutdown, a window of consecutive cool samples.

The outputs are a fan speed target, a PoE limit stage and a request to switch off low-priority ports. Each level change also produces a one-cycle event record, which a logging agent downstream can store. The record holds the new level, a thermal cause code, the hotspot mean and slope, and the exhaust-minus-intake delta. The block does not own the sensor bus, the PWM generator or the log storage.

Top module: `thermal_policy`

## Requirements
- R1: After reset the level is normal (code 0), fan target 0, PoE limit 0, port-off request low and no event pulse.
- R2: From normal, a sample whose slope is at least SLOPE_WARN moves the level to warning (code 1) with fan target 1. The slope is the current hotspot minus the hotspot WIN samples earlier, and it reads 0 until WIN samples have been taken.
- R3: From normal or warning, a hotspot at or above T_DERATE moves the level to derate (code 2). In derate the fan target is 3 and the PoE limit is 1.
- R4: Derate is left only on a sample whose hotspot is below T_DERATE-HYST, with no fan fault, once the dwell has elapsed. The level then steps to warning, never straight to normal.
- R5: A hotspot at or above T_CRIT moves any lower level to shutdown (code 3). Shutdown is the only way into port-off, and it sets fan target 3 and PoE limit 3. Shutdown is never entered below T_CRIT.
- R6: Shutdown steps down to derate on the COOLDOWN-th consecutive sample below T_CRIT-HYST. A warmer sample restarts that count.
- R7: A sample flagged with a fan fault lifts normal or warning to derate. While the latest sample carries the fault, derate uses PoE limit 2, and derate is held.
- R8: No level steps down before the DWELL-th sample after it was entered. Warning returns to normal on a sample whose slope is below SLOPE_WARN once the dwell has elapsed.
- R9: Every level change raises ev_valid for exactly the one cycle after the sample edge, and at no other time. The record holds the new level, the slope of that sample and the outlet minus inlet delta. It also holds the mean of that sample and the WIN-1 preceding ones, floored, with the history cleared to zero at reset.
- R10: Cause codes all have bit 3 set, which marks them as thermal and keeps them apart from budget codes: 9 slope, A threshold, B critical, C fan fault, D recovery.
- R11: The level changes only on cycles where sample_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | A new sample set is present this cycle |
| hot_temp | input | TW | Hotspot temperature |
| inlet_temp | input | TW | Intake air temperature |
| outlet_temp | input | TW | Exhaust air temperature |
| fan_fault | input | 1 | Fan tachometer fault seen with this sample |
| thermal_state | output | 2 | Level: 0 normal, 1 warning, 2 derate, 3 shutdown |
| fan_level | output | 2 | Fan speed target (0 base, 1 raised, 3 maximum) |
| poe_limit | output | 2 | PoE limit stage |
| port_off | output | 1 | Switch off low-priority ports |
| ev_valid | output | 1 | Event record valid, one cycle per level change |
| ev_state | output | 2 | Level entered |
| ev_reason | output | 4 | Thermal cause code |
| ev_avg | output | TW | Windowed hotspot mean |
| ev_slope | output | TW+1 | Signed hotspot slope |
| ev_delta | output | TW+1 | Signed outlet minus inlet |

## Verification
On every cycle, the assertions check the following. The level holds between samples. Any level change comes with an event pulse that carries a thermal cause code. Port-off appears only together with full fan and full PoE limiting. Shutdown is never entered below the critical threshold. Derate never drops straight to normal. The bench scenarios are the only place where the timing-dependent rules can be shown: the exact hysteresis boundary, the dwell count, a cooldown window interrupted by a warm sample, the windowed mean and slope arithmetic, and the fan-fault hold and release.

// File: rtl/thermal_policy.sv
module thermal_policy #(
  parameter int TW         = 10,
  parameter int WIN        = 4,
  parameter int SLOPE_WARN = 6,
  parameter int T_DERATE   = 400,
  parameter int T_CRIT     = 480,
  parameter int HYST       = 20,
  parameter int DWELL      = 3,
  parameter int COOLDOWN   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_valid,
  input  logic [TW-1:0]        hot_temp,
  input  logic [TW-1:0]        inlet_temp,
  input  logic [TW-1:0]        outlet_temp,
  input  logic                 fan_fault,
  output logic [1:0]           thermal_state,
  output logic [1:0]           fan_level,
  output logic [1:0]           poe_limit,
  output logic                 port_off,
  output logic                 ev_valid,
  output logic [1:0]           ev_state,
  output logic [3:0]           ev_reason,
  output logic [TW-1:0]        ev_avg,
  output logic signed [TW:0]   ev_slope,
  output logic signed [TW:0]   ev_delta
);
  localparam int LW   = $clog2(WIN);
  localparam int SW   = TW + LW;
  localparam int CMAX = (DWELL > COOLDOWN) ? DWELL : COOLDOWN;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [TW-1:0] DER_ON   = TW'(T_DERATE);
  localparam logic [TW-1:0] DER_OFF  = TW'(T_DERATE - HYST);
  localparam logic [TW-1:0] CRIT_ON  = TW'(T_CRIT);
  localparam logic [TW-1:0] CRIT_OFF = TW'(T_CRIT - HYST);
  localparam logic signed [TW:0] SLP = (TW+1)'(SLOPE_WARN);

  localparam logic [1:0] NORM = 2'd0, WARN = 2'd1, DRT = 2'd2, SHUT = 2'd3;
  localparam logic [3:0] C_SLOPE = 4'h9, C_LIMIT = 4'hA, C_CRIT = 4'hB,
                         C_FAN = 4'hC, C_RECOV = 4'hD;

  logic [1:0]         st, nxt;
  logic [3:0]         rsn;
  logic [CW-1:0]      cnt;
  logic [LW:0]        fill;
  logic               flt_q;
  logic [TW-1:0]      hist [WIN];
  logic [SW-1:0]      sum;
  logic signed [TW:0] slope, delta;
  logic               filled, rising, cool, dwell_ok;

  assign filled   = (fill == (LW+1)'(WIN));
  assign slope    = filled ? ($signed({1'b0, hot_temp}) - $signed({1'b0, hist[WIN-1]})) : '0;
  assign delta    = $signed({1'b0, outlet_temp}) - $signed({1'b0, inlet_temp});
  assign rising   = (slope >= SLP);
  assign cool     = (hot_temp < CRIT_OFF);
  assign dwell_ok = (cnt >= CW'(DWELL));

  always_comb begin
    sum = {{LW{1'b0}}, hot_temp};
    for (int i = 0; i < WIN - 1; i++) sum = sum + {{LW{1'b0}}, hist[i]};
  end

  always_comb begin
    nxt = st;
    rsn = C_RECOV;
    if (hot_temp >= CRIT_ON && st != SHUT) begin
      nxt = SHUT; rsn = C_CRIT;
    end else if (fan_fault && st < DRT) begin
      nxt = DRT;  rsn = C_FAN;
    end else if (hot_temp >= DER_ON && st < DRT) begin
      nxt = DRT;  rsn = C_LIMIT;
    end else if (rising && st == NORM) begin
      nxt = WARN; rsn = C_SLOPE;
    end else begin
      case (st)
        SHUT: if (cool && cnt >= CW'(COOLDOWN - 1)) nxt = DRT;
        DRT:  if (!fan_fault && hot_temp < DER_OFF && dwell_ok) nxt = WARN;
        WARN: if (!rising && dwell_ok) nxt = NORM;
        default: nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= NORM; cnt <= '0; fill <= '0; flt_q <= 1'b0;
      ev_valid <= 1'b0; ev_state <= NORM; ev_reason <= '0;
      ev_avg <= '0; ev_slope <= '0; ev_delta <= '0;
      for (int i = 0; i < WIN; i++) hist[i] <= '0;
    end else begin
      ev_valid <= 1'b0;
      if (sample_valid) begin
        hist[0] <= hot_temp;
        for (int i = 1; i < WIN; i++) hist[i] <= hist[i-1];
        if (!filled) fill <= fill + 1'b1;
        flt_q <= fan_fault;
        st    <= nxt;
        if (nxt != st) begin
          cnt       <= (nxt == SHUT) ? CW'(0) : CW'(1);
          ev_valid  <= 1'b1;
          ev_state  <= nxt;
          ev_reason <= rsn;
          ev_avg    <= sum[SW-1:LW];
          ev_slope  <= slope;
          ev_delta  <= delta;
        end else if (st == SHUT && !cool) begin
          cnt <= '0;
        end else if (cnt != CW'(CMAX)) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign thermal_state = st;
  assign fan_level     = (st == NORM) ? 2'd0 : (st == WARN) ? 2'd1 : 2'd3;
  assign poe_limit     = (st == SHUT) ? 2'd3 : (st == DRT) ? (flt_q ? 2'd2 : 2'd1) : 2'd0;
  assign port_off      = (st == SHUT);
endmodule

// File: rtl/thermal_policy_chk.sv
module thermal_policy_chk #(
  parameter int TW     = 10,
  parameter int T_CRIT = 480
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_valid,
  input logic [TW-1:0] hot_temp,
  input logic [1:0]    thermal_state,
  input logic [1:0]    fan_level,
  input logic [1:0]    poe_limit,
  input logic          port_off,
  input logic          ev_valid,
  input logic [1:0]    ev_state,
  input logic [3:0]    ev_reason
);
  localparam logic [TW-1:0] CRIT = TW'(T_CRIT);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(thermal_state));

  assert_event_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (thermal_state != $past(thermal_state)) |-> (ev_valid && ev_state == thermal_state));

  assert_thermal_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> ev_reason[3]);

  assert_portoff_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    port_off |-> (fan_level == 2'd3 && poe_limit == 2'd3 && thermal_state == 2'd3));

  assert_shut_needs_crit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(thermal_state) != 2'd3 && thermal_state == 2'd3) |-> ($past(hot_temp) >= CRIT));

  assert_derate_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(thermal_state) == 2'd2) |-> (thermal_state != 2'd0));

  assert_warn_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(thermal_state) == 2'd0 && thermal_state == 2'd1) |-> (ev_reason == 4'h9));
endmodule

bind thermal_policy thermal_policy_chk #(.TW(TW), .T_CRIT(T_CRIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .hot_temp(hot_temp),
  .thermal_state(thermal_state), .fan_level(fan_level), .poe_limit(poe_limit),
  .port_off(port_off), .ev_valid(ev_valid), .ev_state(ev_state), .ev_reason(ev_reason)
);

// File: tb/sim_thermal_policy.sv
module sim_thermal_policy;
  localparam int TW = 10, WIN = 4, SLOPE_WARN = 6, T_DERATE = 400, T_CRIT = 480;
  localparam int HYST = 20, DWELL = 3, COOLDOWN = 5;

  logic clk = 1'b0, rst_n = 1'b0, sample_valid = 1'b0, fan_fault = 1'b0;
  logic [TW-1:0] hot_temp = '0, inlet_temp = '0, outlet_temp = '0;
  logic [1:0] thermal_state, fan_level, poe_limit, ev_state;
  logic port_off, ev_valid;
  logic [3:0] ev_reason;
  logic [TW-1:0] ev_avg;
  logic signed [TW:0] ev_slope, ev_delta;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_st = 0, m_cnt = 0, m_fill = 0;
  int m_hist [WIN];
  bit m_flt = 0;
  bit e_ev = 0;
  int e_rsn = 0, e_avg = 0, e_slope = 0, e_delta = 0;

  always #4 clk = ~clk;

  thermal_policy #(.TW(TW), .WIN(WIN), .SLOPE_WARN(SLOPE_WARN), .T_DERATE(T_DERATE),
    .T_CRIT(T_CRIT), .HYST(HYST), .DWELL(DWELL), .COOLDOWN(COOLDOWN)) u0 (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .hot_temp(hot_temp),
    .inlet_temp(inlet_temp), .outlet_temp(outlet_temp), .fan_fault(fan_fault),
    .thermal_state(thermal_state), .fan_level(fan_level), .poe_limit(poe_limit),
    .port_off(port_off), .ev_valid(ev_valid), .ev_state(ev_state), .ev_reason(ev_reason),
    .ev_avg(ev_avg), .ev_slope(ev_slope), .ev_delta(ev_delta));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int fan_exp(int s);
    return (s == 0) ? 0 : (s == 1) ? 1 : 3;
  endfunction

  function automatic int poe_exp(int s, bit f);
    return (s == 3) ? 3 : (s == 2) ? (f ? 2 : 1) : 0;
  endfunction

  task automatic model(int hot, int inl, int outl, bit ff);
    int slope, sum, nxt, rsn;
    bit rising;
    slope = (m_fill >= WIN) ? hot - m_hist[WIN-1] : 0;
    rising = slope >= SLOPE_WARN;
    sum = hot;
    for (int i = 0; i < WIN - 1; i++) sum += m_hist[i];
    nxt = m_st; rsn = 13;
    if (hot >= T_CRIT && m_st != 3) begin nxt = 3; rsn = 11; end
    else if (ff && m_st < 2) begin nxt = 2; rsn = 12; end
    else if (hot >= T_DERATE && m_st < 2) begin nxt = 2; rsn = 10; end
    else if (rising && m_st == 0) begin nxt = 1; rsn = 9; end
    else if (m_st == 3 && hot < T_CRIT - HYST && m_cnt + 1 >= COOLDOWN) nxt = 2;
    else if (m_st == 2 && !ff && hot < T_DERATE - HYST && m_cnt >= DWELL) nxt = 1;
    else if (m_st == 1 && !rising && m_cnt >= DWELL) nxt = 0;
    e_ev = (nxt != m_st);
    if (e_ev) begin
      e_rsn = rsn; e_avg = sum / WIN; e_slope = slope; e_delta = outl - inl;
      m_cnt = (nxt == 3) ? 0 : 1;
    end else if (m_st == 3 && hot >= T_CRIT - HYST) m_cnt = 0;
    else if (m_cnt < 100) m_cnt++;
    m_st = nxt;
    for (int i = WIN - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
    m_hist[0] = hot;
    if (m_fill < WIN) m_fill++;
    m_flt = ff;
  endtask

  task automatic sample(string req, int hot, int inl, int outl, bit ff);
    @(negedge clk);
    hot_temp = TW'(hot); inlet_temp = TW'(inl); outlet_temp = TW'(outl);
    fan_fault = ff; sample_valid = 1'b1;
    model(hot, inl, outl, ff);
    @(negedge clk);
    sample_valid = 1'b0;
    chk(req, "state", int'(thermal_state), m_st);
    chk(req, "fan", int'(fan_level), fan_exp(m_st));
    chk(req, "poe", int'(poe_limit), poe_exp(m_st, m_flt));
    chk(req, "port_off", int'(port_off), (m_st == 3) ? 1 : 0);
    chk("R9", "ev_valid", int'(ev_valid), int'(e_ev));
    if (e_ev) begin
      chk("R9", "ev_state", int'(ev_state), m_st);
      chk("R10", "ev_reason", int'(ev_reason), e_rsn);
      chk("R9", "ev_avg", int'(ev_avg), e_avg);
      chk("R9", "ev_slope", int'(ev_slope), e_slope);
      chk("R9", "ev_delta", int'(ev_delta), e_delta);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int hot;
    bit ff;
    for (int i = 0; i < WIN; i++) m_hist[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "state", int'(thermal_state), 0);
    chk("R1", "fan", int'(fan_level), 0);
    chk("R1", "poe", int'(poe_limit), 0);
    chk("R1", "port_off", int'(port_off), 0);
    chk("R1", "ev_valid", int'(ev_valid), 0);

    // R2 slope-driven warning after history fills
    for (int i = 0; i < WIN; i++) sample("R2", 300, 250, 270, 0);
    sample("R2", 310, 250, 275, 0);
    chk("R2", "warn", int'(thermal_state), 1);
    // R8 dwell and return to normal on flat slope
    sample("R8", 310, 250, 275, 0);
    chk("R8", "dwell_hold", int'(thermal_state), 1);
    for (int i = 0; i < 6; i++) sample("R8", 310, 250, 275, 0);
    chk("R8", "back_normal", int'(thermal_state), 0);

    // R3 threshold derate
    sample("R3", 405, 260, 300, 0);
    chk("R3", "derate", int'(thermal_state), 2);
    // R4 hysteresis boundary
    for (int i = 0; i < 5; i++) sample("R4", T_DERATE - HYST, 260, 300, 0);
    chk("R4", "hold_at_edge", int'(thermal_state), 2);
    sample("R4", T_DERATE - HYST - 1, 260, 300, 0);
    chk("R4", "step_to_warn", int'(thermal_state), 1);

    // R5 critical from warning
    sample("R5", T_CRIT, 270, 330, 0);
    chk("R5", "shutdown", int'(port_off), 1);
    // R6 cooldown, interrupted by a warm sample
    for (int i = 0; i < 3; i++) sample("R6", T_CRIT - HYST - 1, 260, 300, 0);
    sample("R6", T_CRIT - HYST + 5, 260, 300, 0);
    for (int i = 0; i < COOLDOWN - 1; i++) sample("R6", T_CRIT - HYST - 1, 260, 300, 0);
    chk("R6", "still_shut", int'(thermal_state), 3);
    sample("R6", T_CRIT - HYST - 1, 260, 300, 0);
    chk("R6", "to_derate", int'(thermal_state), 2);

    // R7 fan fault from normal
    for (int i = 0; i < 12; i++) sample("R7", 300, 250, 270, 0);
    chk("R7", "settled", int'(thermal_state), 0);
    sample("R7", 300, 250, 270, 1);
    chk("R7", "fault_derate", int'(poe_limit), 2);
    for (int i = 0; i < 5; i++) sample("R7", 300, 250, 270, 1);
    chk("R7", "fault_hold", int'(thermal_state), 2);
    sample("R7", 300, 250, 270, 0);

    // R11 no change without samples
    hot_temp = TW'(500); fan_fault = 1'b1;
    repeat (10) @(negedge clk);
    chk("R11", "idle_state", int'(thermal_state), m_st);
    chk("R11", "idle_event", int'(ev_valid), 0);
    fan_fault = 1'b0;

    // randomized walk
    void'($urandom(32'd2024));
    hot = 320;
    for (int n = 0; n < 600; n++) begin
      hot += int'($urandom_range(0, 30)) - 14;
      if ($urandom_range(0, 40) == 0) hot += 90;
      if (hot < 250) hot = 250;
      if (hot > 520) hot = 520;
      ff = ($urandom_range(0, 24) == 0);
      sample("RND", hot, int'($urandom_range(200, 300)), int'($urandom_range(200, 400)), ff);
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
    end
    finish_run();
  end
endmodule